// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Mapper

This block is the banking core of an 8-bit console cartridge controller. The CPU programs it by writing into the $8000-$FFFF space. Those writes land in a small set of registers: one byte chooses the modes and names a target bank register, and the next data write loads that target. From the live CPU address the block forms an 18-bit PRG ROM address covering 256 KiB in 8 KiB windows. From the PPU pattern-table address it forms an 18-bit CHR address. It also drives a single nametable mirroring bit.

Three 8 KiB CPU windows can be switched and the top window is pinned to the last bank. The two PRG registers for the lower and upper windows trade places under a mode bit. On the CHR side the 8 KiB pattern space is split into two 4 KiB halves. One half always uses four 1 KiB banks. The other half uses either two 2 KiB banks or four 1 KiB banks, and a further mode bit swaps which half is which. All outputs are combinational from the registers, so a register change shows on the outputs right after the clock edge that takes the write.

Top module: `bank_mapper_top`

## Requirements
- R1: When rst_n is low, every register clears to zero. After reset, all three switchable PRG windows map to bank 0, every CHR bank is 0, and mirror_horiz is 0 (vertical).
- R2: A write takes effect only when cpu_wr_en is high and cpu_addr[15] is 1. cpu_addr[14:13] picks the register pair and cpu_addr[0] picks its even (0) or odd (1) member. Writes with cpu_addr[15]=0 change nothing, and so do writes to the pairs at $C000 and $E000.
- R3: An even write in the $8000 pair stores the control byte: bit 7 = CHR half inversion, bit 6 = PRG swap, bit 5 = fine CHR mode, bits 3:0 = target index. An odd write in that pair loads all 8 data bits into the target register.
- R4: Target indexes 0-9 and 15 name implemented bank registers. A data write aimed at an index from 10 to 14 leaves every bank register unchanged.
- R5: CPU window 3 ($E000-$FFFF) always uses PRG bank 31. Window 1 ($A000-$BFFF) always uses register 7.
- R6: With PRG swap 0, window 0 uses register 6 and window 2 uses register 15. With PRG swap 1, window 0 uses register 15 and window 2 uses register 6.
- R7: With fine mode 0, the low CHR half uses register 0 for its first 2 KiB and register 1 for its second 2 KiB. Bit 0 of the register is replaced by ppu_addr[10].
- R8: With fine mode 1, the low CHR half uses 1 KiB banks from registers 0, 8, 1 and 9, for ppu_addr[11:10] = 0, 1, 2 and 3 in that order.
- R9: The high CHR half uses registers 2, 3, 4 and 5 as 1 KiB banks, for ppu_addr[11:10] = 0 to 3.
- R10: The CHR half is chosen by ppu_addr[12] XOR the inversion bit. With inversion set, PPU $0000-$0FFF reads the high-half banks and PPU $1000-$1FFF reads the low-half banks.
- R11: An even write in the $A000 pair sets mirror_horiz to data bit 0 (0 vertical, 1 horizontal). An odd write in that pair has no effect.
- R12: prg_addr = {bank[4:0], cpu_addr[12:0]}. chr_addr = {bank[7:0], ppu_addr[9:0]}, where bank is the register value after the R7 substitution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which register writes are taken |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used both for write decode and for PRG mapping |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | PPU pattern-table address |
| prg_addr | output | 18 | PRG ROM address |
| chr_addr | output | 18 | CHR memory address |
| mirror_horiz | output | 1 | Nametable mirroring: 0 vertical, 1 horizontal |

## Verification
The assertions check the address mapping on every cycle. They cover the fixed top window, the register 7 window, the swap of registers 6 and 15, the pass-through of ppu_addr[10] in 2 KiB mode, and the offset bits. They also check that ignored writes (low addresses and unused indexes) leave state stable, and that mirroring follows the last $A000 write. The order of the R0/R8/R1/R9 banks in fine mode, the high-half bank order and the effect of inversion across all combinations are shown only by the bench's scenarios. These scenarios compare each CHR and PRG window against a separately kept model after random sequences of control and data writes.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int BYTE_W     = 8;
  localparam int IDX_W      = 4;
  localparam int NUM_SLOTS  = 1 << IDX_W;
  localparam int PRG_BANK_W = 5;
  localparam int CHR_BANK_W = 8;
  localparam int PRG_OFS_W  = 13;
  localparam int CHR_OFS_W  = 10;
  localparam int PRG_ADDR_W = PRG_BANK_W + PRG_OFS_W;
  localparam int CHR_ADDR_W = CHR_BANK_W + CHR_OFS_W;

  localparam logic [IDX_W-1:0] SLOT_PRG_LO  = 4'd6;
  localparam logic [IDX_W-1:0] SLOT_PRG_MID = 4'd7;
  localparam logic [IDX_W-1:0] SLOT_PRG_ALT = 4'd15;

  typedef enum logic [1:0] {
    WIN_LOW  = 2'd0,
    WIN_MID  = 2'd1,
    WIN_HIGH = 2'd2,
    WIN_TOP  = 2'd3
  } prg_win_e;

  typedef struct packed {
    logic             chr_inv;
    logic             prg_swap;
    logic             chr_fine;
    logic [IDX_W-1:0] target;
  } ctrl_t;

  // Byte layout of the control register; bit 4 carries nothing.
  function automatic ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] b);
    ctrl_t c;
    c.chr_inv  = b[7];
    c.prg_swap = b[6];
    c.chr_fine = b[5];
    c.target   = b[3:0];
    return c;
  endfunction

  // Indexes that hold a bank register.
  function automatic logic slot_exists(input int unsigned idx);
    return (idx <= 9) || (idx == 15);
  endfunction

  // Which register feeds a switchable CPU window.
  function automatic logic [IDX_W-1:0] prg_slot(input logic swap, input prg_win_e w);
    logic [IDX_W-1:0] s;
    case (w)
      WIN_LOW:  s = swap ? SLOT_PRG_ALT : SLOT_PRG_LO;
      WIN_HIGH: s = swap ? SLOT_PRG_LO  : SLOT_PRG_ALT;
      default:  s = SLOT_PRG_MID;
    endcase
    return s;
  endfunction

  // Which register feeds a 1 KiB PPU slot given A12..A10.
  function automatic logic [IDX_W-1:0] chr_slot(input logic inv, input logic fine,
                                                input logic [2:0] a);
    logic [IDX_W-1:0] s;
    if (a[2] ^ inv) begin
      s = 4'd2 + {2'b00, a[1:0]};
    end else if (fine) begin
      case (a[1:0])
        2'd0:    s = 4'd0;
        2'd1:    s = 4'd8;
        2'd2:    s = 4'd1;
        default: s = 4'd9;
      endcase
    end else begin
      s = {3'b000, a[1]};
    end
    return s;
  endfunction

  // True when a slot uses the 2 KiB form (A10 replaces bank bit 0).
  function automatic logic chr_coarse(input logic inv, input logic fine, input logic a12);
    return !(a12 ^ inv) && !fine;
  endfunction

endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
  import mapper_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        a15,
  input  logic [1:0]                  pair,
  input  logic                        odd,
  input  logic [BYTE_W-1:0]           wdata,
  output ctrl_t                       ctrl_q,
  output logic [NUM_SLOTS*BYTE_W-1:0] bank_flat,
  output logic                        mirror_q,
  output logic                        ev_ctrl_wr,
  output logic                        ev_data_wr,
  output logic                        ev_mirror_wr
);

  logic hit;
  assign hit          = wr_en && a15;
  assign ev_ctrl_wr   = hit && (pair == 2'd0) && !odd;
  assign ev_data_wr   = hit && (pair == 2'd0) &&  odd;
  assign ev_mirror_wr = hit && (pair == 2'd1) && !odd;

  logic unused_bit4;
  assign unused_bit4 = wdata[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ev_ctrl_wr) begin
      ctrl_q <= unpack_ctrl(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mirror_q <= 1'b0;
    end else if (ev_mirror_wr) begin
      mirror_q <= wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (slot_exists(i)) begin : g_real
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= '0;
        end else if (ev_data_wr && (ctrl_q.target == IDX_W'(i))) begin
          q <= wdata;
        end
      end
      assign bank_flat[i*BYTE_W +: BYTE_W] = q;
    end else begin : g_none
      assign bank_flat[i*BYTE_W +: BYTE_W] = '0;
    end
  end

endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
  import mapper_pkg::*;
(
  input  logic                        prg_swap,
  input  logic [NUM_SLOTS*BYTE_W-1:0] bank_flat,
  input  logic [14:0]                 cpu_addr,
  output logic [PRG_ADDR_W-1:0]       prg_addr
);

  prg_win_e              win;
  logic [IDX_W-1:0]      slot;
  logic [BYTE_W-1:0]     raw;
  logic [PRG_BANK_W-1:0] bank;
  logic                  unused_hi;

  assign win  = prg_win_e'(cpu_addr[14:13]);
  assign slot = prg_slot(prg_swap, win);
  assign raw  = bank_flat[slot*BYTE_W +: BYTE_W];
  assign unused_hi = ^raw[BYTE_W-1:PRG_BANK_W];

  always_comb begin
    if (win == WIN_TOP) bank = '1;
    else                bank = raw[PRG_BANK_W-1:0];
  end

  assign prg_addr = {bank, cpu_addr[PRG_OFS_W-1:0]};

endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
  import mapper_pkg::*;
(
  input  logic                        chr_inv,
  input  logic                        chr_fine,
  input  logic [NUM_SLOTS*BYTE_W-1:0] bank_flat,
  input  logic [12:0]                 ppu_addr,
  output logic [CHR_ADDR_W-1:0]       chr_addr
);

  logic [IDX_W-1:0]      slot;
  logic [CHR_BANK_W-1:0] raw;
  logic [CHR_BANK_W-1:0] bank;
  logic                  coarse;

  assign slot   = chr_slot(chr_inv, chr_fine, ppu_addr[12:10]);
  assign raw    = bank_flat[slot*BYTE_W +: BYTE_W];
  assign coarse = chr_coarse(chr_inv, chr_fine, ppu_addr[12]);
  assign bank   = coarse ? {raw[CHR_BANK_W-1:1], ppu_addr[10]} : raw;

  assign chr_addr = {bank, ppu_addr[CHR_OFS_W-1:0]};

endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
  import mapper_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_wr_en,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic [12:0]           ppu_addr,
  output logic [PRG_ADDR_W-1:0] prg_addr,
  output logic [CHR_ADDR_W-1:0] chr_addr,
  output logic                  mirror_horiz
);

  ctrl_t                       ctrl_q;
  logic [NUM_SLOTS*BYTE_W-1:0] bank_flat;
  logic                        mirror_q;
  logic                        ev_ctrl_wr;
  logic                        ev_data_wr;
  logic                        ev_mirror_wr;

  mapper_regfile u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cpu_wr_en),
    .a15          (cpu_addr[15]),
    .pair         (cpu_addr[14:13]),
    .odd          (cpu_addr[0]),
    .wdata        (cpu_wdata),
    .ctrl_q       (ctrl_q),
    .bank_flat    (bank_flat),
    .mirror_q     (mirror_q),
    .ev_ctrl_wr   (ev_ctrl_wr),
    .ev_data_wr   (ev_data_wr),
    .ev_mirror_wr (ev_mirror_wr)
  );

  mapper_prg_map u_prg (
    .prg_swap  (ctrl_q.prg_swap),
    .bank_flat (bank_flat),
    .cpu_addr  (cpu_addr[14:0]),
    .prg_addr  (prg_addr)
  );

  mapper_chr_map u_chr (
    .chr_inv   (ctrl_q.chr_inv),
    .chr_fine  (ctrl_q.chr_fine),
    .bank_flat (bank_flat),
    .ppu_addr  (ppu_addr),
    .chr_addr  (chr_addr)
  );

  assign mirror_horiz = mirror_q;

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
  import mapper_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cpu_wr_en,
  input logic [15:0]                 cpu_addr,
  input logic [7:0]                  cpu_wdata,
  input logic [12:0]                 ppu_addr,
  input logic [PRG_ADDR_W-1:0]       prg_addr,
  input logic [CHR_ADDR_W-1:0]       chr_addr,
  input logic                        mirror_horiz,
  input ctrl_t                       ctrl_q,
  input logic [NUM_SLOTS*BYTE_W-1:0] bank_flat,
  input logic                        ev_data_wr
);

  assert_top_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'd3) |-> (prg_addr[17:13] == 5'd31));

  assert_mid_uses_r7_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'd1) |-> (prg_addr[17:13] == bank_flat[7*8 +: 5]));

  assert_low_win_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'd0) |->
      (prg_addr[17:13] == (ctrl_q.prg_swap ? bank_flat[15*8 +: 5] : bank_flat[6*8 +: 5])));

  assert_high_win_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'd2) |->
      (prg_addr[17:13] == (ctrl_q.prg_swap ? bank_flat[6*8 +: 5] : bank_flat[15*8 +: 5])));

  assert_a10_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.chr_fine && !(ppu_addr[12] ^ ctrl_q.chr_inv)) |-> (chr_addr[10] == ppu_addr[10]));

  assert_offsets_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_addr[9:0] == ppu_addr[9:0]) && (prg_addr[12:0] == cpu_addr[12:0]));

  assert_mirror_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && cpu_addr[15:13] == 3'b101 && !cpu_addr[0]) |=> (mirror_horiz == $past(cpu_wdata[0])));

  assert_low_space_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !cpu_addr[15]) |=> ($stable(ctrl_q) && $stable(bank_flat) && $stable(mirror_horiz)));

  assert_bad_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_wr && ctrl_q.target >= 4'd10 && ctrl_q.target <= 4'd14) |=> $stable(bank_flat));

endmodule

bind bank_mapper_top bank_mapper_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .ppu_addr     (ppu_addr),
  .prg_addr     (prg_addr),
  .chr_addr     (chr_addr),
  .mirror_horiz (mirror_horiz),
  .ctrl_q       (ctrl_q),
  .bank_flat    (bank_flat),
  .ev_data_wr   (ev_data_wr)
);

// File: tb/bank_mapper_top_tb.sv
module bank_mapper_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [12:0] ppu_addr = 13'h0000;
  logic [17:0] prg_addr;
  logic [17:0] chr_addr;
  logic        mirror_horiz;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model of the visible state
  logic [7:0] m_reg [16];
  logic       m_inv, m_swap, m_fine, m_mir;
  logic [3:0] m_tgt;

  always #10 clk = ~clk;

  bank_mapper_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .chr_addr(chr_addr), .mirror_horiz(mirror_horiz)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h (cpu=%h ppu=%h)", req, got, exp, cpu_addr, ppu_addr);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_inv = 0; m_swap = 0; m_fine = 0; m_mir = 0; m_tgt = 0;
  endtask

  // R2/R3/R4/R11 model of the write decode
  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a[15]) begin
      if (a[14:13] == 2'b00 && a[0] == 1'b0) begin
        m_inv = d[7]; m_swap = d[6]; m_fine = d[5]; m_tgt = d[3:0];
      end else if (a[14:13] == 2'b00) begin
        if (m_tgt < 4'd10 || m_tgt == 4'd15) m_reg[m_tgt] = d;
      end else if (a[14:13] == 2'b01 && a[0] == 1'b0) begin
        m_mir = d[0];
      end
    end
  endtask

  function automatic logic [17:0] exp_prg(input logic [15:0] a);
    logic [4:0] b;
    if (a[14] && a[13])       b = 5'h1F;
    else if (a[13])           b = m_reg[7][4:0];
    else if (a[14] == m_swap) b = m_reg[6][4:0];
    else                      b = m_reg[15][4:0];
    return {b, a[12:0]};
  endfunction

  function automatic logic [17:0] exp_chr(input logic [12:0] p);
    logic [7:0] b;
    int q;
    q = p[11:10];
    if (p[12] != m_inv) b = m_reg[2 + q];
    else if (m_fine)    b = (q == 0) ? m_reg[0] : (q == 1) ? m_reg[8] : (q == 2) ? m_reg[1] : m_reg[9];
    else                b = {m_reg[p[11]][7:1], p[10]};
    return {b, p[9:0]};
  endfunction

  function automatic string chr_req(input logic [12:0] p);
    if (m_inv)          return "R10";
    if (p[12])          return "R9";
    if (m_fine)         return "R8";
    return "R7";
  endfunction

  function automatic string prg_req(input logic [15:0] a);
    if (a[14:13] == 2'd3) return "R5";
    if (a[14:13] == 2'd1) return "R5";
    return "R6";
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    cpu_wr_en = en; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    if (en) model_write(a, d);
  endtask

  task automatic probe_prg(input logic [15:0] a);
    cpu_addr = a; #1;
    check(prg_req(a), 32'(prg_addr), 32'(exp_prg(a)));
  endtask

  task automatic probe_chr(input logic [12:0] p);
    ppu_addr = p; #1;
    check(chr_req(p), 32'(chr_addr), 32'(exp_chr(p)));
  endtask

  // Walks every window of both maps: reveals all register contents (R12 offsets too)
  task automatic sweep();
    for (int w = 0; w < 4; w++) probe_prg(16'h8000 | 16'(w << 13) | 16'h0ABC);
    for (int s = 0; s < 8; s++) probe_chr(13'(s << 10) | 13'h155);
    check("R11", 32'(mirror_horiz), 32'(m_mir));
  endtask

  task automatic load(input logic [7:0] ctl, input logic [7:0] d);
    bus_write(16'h8000, ctl);
    bus_write(16'h8001, d);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    sweep();

    // R3, R5, R6, R12: load PRG registers with distinct values, both swap settings
    load(8'h06, 8'hE3);  // R6 <- bank 3, bits above 4 dropped (R12)
    load(8'h07, 8'h0A);
    load(8'h0F, 8'h15);
    sweep();
    bus_write(16'h8000, 8'h40); // swap on
    sweep();

    // R7, R8, R9: CHR banks, coarse then fine
    for (int i = 0; i < 10; i++) load(8'h00 | 8'(i), 8'(8'h31 + 8'(i * 17)));
    bus_write(16'h8000, 8'h00);
    sweep();
    bus_write(16'h8000, 8'h20);
    sweep();
    // R10: inversion with both CHR modes
    bus_write(16'h8000, 8'hA0);
    sweep();
    bus_write(16'h8000, 8'h80);
    sweep();

    // R4: unused indexes 10..14 leave all banks unchanged
    for (int i = 10; i < 15; i++) load(8'(i), 8'h5A);
    sweep();

    // R11: mirroring on even $A000 write; odd $A001 ignored
    bus_write(16'hA000, 8'h01);
    sweep();
    bus_write(16'hA001, 8'h00);
    sweep();
    bus_write(16'hBFFE, 8'hFE);
    sweep();

    // R2: writes below $8000, to $C000/$E000 pairs, or without strobe change nothing
    bus_write(16'h0000, 8'hFF);
    bus_write(16'h2001, 8'hFF);
    bus_write(16'hC000, 8'hFF);
    bus_write(16'hE001, 8'hFF);
    bus_write(16'h8000, 8'hFF, 1'b0);
    bus_write(16'hA000, 8'hFF, 1'b0);
    sweep();

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int k;
      k = $urandom % 8;
      d = 8'($urandom);
      case (k)
        0, 1, 2: a = 16'h8000 | (16'($urandom) & 16'h1FFE);
        3, 4:    a = 16'h8001 | (16'($urandom) & 16'h1FFE);
        5:       a = 16'hA000 | (16'($urandom) & 16'h1FFE);
        6:       a = 16'hA001 | (16'($urandom) & 16'h1FFE);
        default: a = 16'($urandom);
      endcase
      bus_write(a, d);
      for (int j = 0; j < 3; j++) probe_prg(16'h8000 | 16'($urandom));
      for (int j = 0; j < 3; j++) probe_chr(13'($urandom));
      check("R11", 32'(mirror_horiz), 32'(m_mir));
    end
    sweep();

    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_clear();
    sweep();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule